// File: doc/BRIEF.md
# Converter Power-Up Initialization Sequencer

This block decides when a converter's sample stream may be trusted after an active-low power-down input is released. It synchronizes the power-down input to the master clock. It then steps through four states: powered down, waiting for a frame-clock start edge, initializing, and running. While initializing, it counts frame-clock rising edges until a mode-dependent number of frames has passed.

Until the running state is reached, both channel outputs are forced to two's-complement zero and a data-valid flag stays low. The filter datapath is kept in reset only while the block is powered down. In master mode the count begins as soon as power-down is released. In slave mode the block first waits for the frame-clock edge that the serial format calls for: a rising edge for left-justified data, or a falling edge for the I2S format.

Top module: `pdn_init_sequencer`

## Requirements
- R1: After the system reset `rstN` is released, `seqState` reads 0 (powered down), `dataValid` is 0, `filterRstN` is 0 and both sample outputs are 0.
- R2: `pdnIn` passes through a two-flop synchronizer. The state leaves power-down at the second clock edge after the first edge that samples `pdnIn` high.
- R3: With `masterMode`=1, power-down leads directly to initialization (`seqState`=2). With `masterMode`=0, it leads to waiting (`seqState`=1).
- R4: In the waiting state, the block stays put until the start edge is sampled. With `i2sMode`=0 the start edge is a frame-clock rise (`lrckIn` sampled 0 then 1). With `i2sMode`=1 it is a fall (sampled 1 then 0). On the edge where it is seen, the state becomes 2.
- R5: In initialization the block counts sampled `lrckIn` rises. The edge that enters initialization is not counted. It enters running (`seqState`=3) on the edge where the MASTER_FRAMES-th rise (master) or the SLAVE_FRAMES-th rise (slave) is seen.
- R6: While `seqState` is not 3, both `sampleLeftOut` and `sampleRightOut` are zero, whatever the sample inputs carry.
- R7: `dataValid` is 1 exactly in state 3. In that same cycle, both sample outputs equal the sample inputs, with no register delay.
- R8: A `pdnIn` low sampled at any clock edge returns the block to state 0 two edges later, from any state. It clears the frame count, so the next release needs the full count again.
- R9: `filterRstN` is 0 exactly when `seqState` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; the frame clock is synchronous to it |
| rstN | input | 1 | Asynchronous active-low system reset |
| pdnIn | input | 1 | Active-low power-down request, asynchronous |
| masterMode | input | 1 | 1: master timing, 0: slave timing |
| i2sMode | input | 1 | 1: I2S format (falling start edge), 0: left-justified |
| lrckIn | input | 1 | Frame clock, synchronous to clk |
| sampleLeftIn | input | SAMPLE_W | Left sample from the filter |
| sampleRightIn | input | SAMPLE_W | Right sample from the filter |
| sampleLeftOut | output | SAMPLE_W | Left sample, zero unless running |
| sampleRightOut | output | SAMPLE_W | Right sample, zero unless running |
| dataValid | output | 1 | High while samples pass through |
| filterRstN | output | 1 | Active-low reset for the filter datapath |
| seqState | output | 2 | 0 down, 1 waiting, 2 initializing, 3 running |

## Verification
The bench sets MASTER_FRAMES to 5 and SLAVE_FRAMES to 8, so every path through the state machine completes within a few hundred cycles. This makes it practical to hit the last-frame boundary, a power-down during initialization followed by a full recount, a power-down during waiting, and a held frame clock in slave mode. Both start-edge polarities and both modes are covered. The frame clock runs with a six-cycle period, which places rises at varied offsets from each release.

// File: rtl/pdnseq_pkg.sv
package pdnseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_INIT = 2'd2,
    ST_RUN  = 2'd3
  } seqState_e;

  // control -> datapath
  typedef struct packed {
    logic passSamples;
    logic filterEnable;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pdnHigh;
    logic lrckRise;
    logic lrckFall;
  } inEvent_t;

endpackage

// File: rtl/pdnseq_datapath.sv
module pdnseq_datapath
  import pdnseq_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pdnIn,
  input  logic                lrckIn,
  input  logic [SAMPLE_W-1:0] sampleLeftIn,
  input  logic [SAMPLE_W-1:0] sampleRightIn,
  input  ctrlStrobe_t         strobes,
  output inEvent_t            events,
  output logic [SAMPLE_W-1:0] sampleLeftOut,
  output logic [SAMPLE_W-1:0] sampleRightOut,
  output logic                dataValid,
  output logic                filterRstN
);

  localparam int NUM_CH = 2;

  logic [SYNC_STAGES-1:0] pdnPipe;
  logic                   lrckQ;

  // power-down synchronizer, resets to "powered down"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdnPipe <= '0;
    else       pdnPipe <= {pdnPipe[SYNC_STAGES-2:0], pdnIn};
  end

  // frame-clock edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lrckQ <= 1'b0;
    else       lrckQ <= lrckIn;
  end

  always_comb begin
    events.pdnHigh  = pdnPipe[SYNC_STAGES-1];
    events.lrckRise = lrckIn & ~lrckQ;
    events.lrckFall = ~lrckIn & lrckQ;
  end

  logic [NUM_CH-1:0][SAMPLE_W-1:0] chIn;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] chOut;

  assign chIn[0] = sampleLeftIn;
  assign chIn[1] = sampleRightIn;

  // per-channel zero forcing
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chOut[g] = strobes.passSamples ? chIn[g] : '0;
  end

  assign sampleLeftOut  = chOut[0];
  assign sampleRightOut = chOut[1];
  assign dataValid      = strobes.passSamples;
  assign filterRstN     = strobes.filterEnable;

endmodule

// File: rtl/pdnseq_control.sv
module pdnseq_control
  import pdnseq_pkg::*;
#(
  parameter int MASTER_FRAMES = 4129,
  parameter int SLAVE_FRAMES  = 4132
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        masterMode,
  input  logic        i2sMode,
  input  inEvent_t    events,
  output ctrlStrobe_t strobes,
  output seqState_e   stateOut
);

  localparam int MAX_FRAMES = (MASTER_FRAMES > SLAVE_FRAMES) ? MASTER_FRAMES : SLAVE_FRAMES;
  localparam int CNT_W      = $clog2(MAX_FRAMES + 1);
  localparam logic [CNT_W-1:0] MASTER_LAST = CNT_W'(MASTER_FRAMES - 1);
  localparam logic [CNT_W-1:0] SLAVE_LAST  = CNT_W'(SLAVE_FRAMES - 1);

  seqState_e        state, stateNxt;
  logic [CNT_W-1:0] frameCnt, frameCntNxt;
  logic [CNT_W-1:0] lastFrame;
  logic             startEdge;

  always_comb begin
    lastFrame   = masterMode ? MASTER_LAST : SLAVE_LAST;
    startEdge   = i2sMode ? events.lrckFall : events.lrckRise;
    stateNxt    = state;
    frameCntNxt = frameCnt;
    if (!events.pdnHigh) begin
      stateNxt    = ST_OFF;
      frameCntNxt = '0;
    end else begin
      case (state)
        ST_OFF: begin
          stateNxt    = masterMode ? ST_INIT : ST_WAIT;
          frameCntNxt = '0;
        end
        ST_WAIT: begin
          if (startEdge) begin
            stateNxt    = ST_INIT;
            frameCntNxt = '0;
          end
        end
        ST_INIT: begin
          if (events.lrckRise) begin
            if (frameCnt == lastFrame) begin
              stateNxt    = ST_RUN;
              frameCntNxt = '0;
            end else begin
              frameCntNxt = frameCnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      frameCnt <= '0;
    end else begin
      state    <= stateNxt;
      frameCnt <= frameCntNxt;
    end
  end

  always_comb begin
    strobes.passSamples  = (state == ST_RUN);
    strobes.filterEnable = (state != ST_OFF);
  end

  assign stateOut = state;

endmodule

// File: rtl/pdn_init_sequencer.sv
module pdn_init_sequencer
  import pdnseq_pkg::*;
#(
  parameter int SAMPLE_W      = 24,
  parameter int MASTER_FRAMES = 4129,
  parameter int SLAVE_FRAMES  = 4132
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pdnIn,
  input  logic                masterMode,
  input  logic                i2sMode,
  input  logic                lrckIn,
  input  logic [SAMPLE_W-1:0] sampleLeftIn,
  input  logic [SAMPLE_W-1:0] sampleRightIn,
  output logic [SAMPLE_W-1:0] sampleLeftOut,
  output logic [SAMPLE_W-1:0] sampleRightOut,
  output logic                dataValid,
  output logic                filterRstN,
  output logic [1:0]          seqState
);

  ctrlStrobe_t strobes;
  inEvent_t    events;
  seqState_e   stateW;

  pdnseq_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .SYNC_STAGES(2)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .pdnIn         (pdnIn),
    .lrckIn        (lrckIn),
    .sampleLeftIn  (sampleLeftIn),
    .sampleRightIn (sampleRightIn),
    .strobes       (strobes),
    .events        (events),
    .sampleLeftOut (sampleLeftOut),
    .sampleRightOut(sampleRightOut),
    .dataValid     (dataValid),
    .filterRstN    (filterRstN)
  );

  pdnseq_control #(
    .MASTER_FRAMES(MASTER_FRAMES),
    .SLAVE_FRAMES (SLAVE_FRAMES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterMode(masterMode),
    .i2sMode   (i2sMode),
    .events    (events),
    .strobes   (strobes),
    .stateOut  (stateW)
  );

  assign seqState = stateW;

endmodule

// File: rtl/pdnseq_checker.sv
module pdnseq_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                pdnIn,
  input logic                masterMode,
  input logic [SAMPLE_W-1:0] sampleLeftIn,
  input logic [SAMPLE_W-1:0] sampleRightIn,
  input logic [SAMPLE_W-1:0] sampleLeftOut,
  input logic [SAMPLE_W-1:0] sampleRightOut,
  input logic                dataValid,
  input logic                filterRstN,
  input logic [1:0]          seqState
);

  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> (sampleLeftOut == '0 && sampleRightOut == '0)); // R6

  AST_PASS_WHEN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (sampleLeftOut == sampleLeftIn && sampleRightOut == sampleRightIn)); // R7

  AST_PDN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pdnIn, 3) |-> (seqState == 2'd0 && !dataValid)); // R8

  AST_LEAVE_OFF_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(seqState) == 2'd0 && seqState != 2'd0) |-> $past(pdnIn, 3)); // R2

  AST_RUN_FROM_INIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(seqState) == 2'd2); // R5

  AST_WAIT_ONLY_SLAVE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(seqState) == 2'd0 && seqState == 2'd1) |-> !$past(masterMode)); // R3

  AST_FILTER_RESET_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !filterRstN |-> (seqState == 2'd0)); // R9

endmodule

bind pdn_init_sequencer pdnseq_checker #(.SAMPLE_W(SAMPLE_W)) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .pdnIn         (pdnIn),
  .masterMode    (masterMode),
  .sampleLeftIn  (sampleLeftIn),
  .sampleRightIn (sampleRightIn),
  .sampleLeftOut (sampleLeftOut),
  .sampleRightOut(sampleRightOut),
  .dataValid     (dataValid),
  .filterRstN    (filterRstN),
  .seqState      (seqState)
);

// File: tb/test_pdn_init_sequencer.sv
module test_pdn_init_sequencer;

  localparam int SW      = 24;
  localparam int MFRAMES = 5;
  localparam int SFRAMES = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pdnIn = 1'b0;
  logic          masterMode = 1'b1;
  logic          i2sMode = 1'b0;
  logic          lrckIn = 1'b0;
  logic [SW-1:0] sampleLeftIn = '0;
  logic [SW-1:0] sampleRightIn = '0;
  logic [SW-1:0] sampleLeftOut, sampleRightOut;
  logic          dataValid, filterRstN;
  logic [1:0]    seqState;

  always #2.5 clk = ~clk;

  pdn_init_sequencer #(
    .SAMPLE_W(SW), .MASTER_FRAMES(MFRAMES), .SLAVE_FRAMES(SFRAMES)
  ) i_pdn_init_sequencer (
    .clk(clk), .rstN(rstN), .pdnIn(pdnIn), .masterMode(masterMode),
    .i2sMode(i2sMode), .lrckIn(lrckIn), .sampleLeftIn(sampleLeftIn),
    .sampleRightIn(sampleRightIn), .sampleLeftOut(sampleLeftOut),
    .sampleRightOut(sampleRightOut), .dataValid(dataValid),
    .filterRstN(filterRstN), .seqState(seqState)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // behavioural reference
  bit pdnHist[$];
  bit mLrckPrev = 0;
  int mState = 0;
  int mRises = 0;

  bit lrckRun = 0;
  int lrckDiv = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic modelReset();
    pdnHist.delete();
    pdnHist.push_back(1'b0);
    pdnHist.push_back(1'b0);
    mLrckPrev = 0; mState = 0; mRises = 0;
  endtask

  task automatic modelStep();
    bit syncedHigh;
    bit rise, fall;
    int limit;
    syncedHigh = pdnHist[1];
    rise  = lrckIn && !mLrckPrev;
    fall  = !lrckIn && mLrckPrev;
    limit = masterMode ? MFRAMES : SFRAMES;
    if (!syncedHigh) begin
      mState = 0; mRises = 0;
    end else if (mState == 0) begin
      mState = masterMode ? 2 : 1; mRises = 0;
    end else if (mState == 1) begin
      if (i2sMode ? fall : rise) begin mState = 2; mRises = 0; end
    end else if (mState == 2) begin
      if (rise) begin
        mRises++;
        if (mRises == limit) begin mState = 3; mRises = 0; end
      end
    end
    void'(pdnHist.pop_back());
    pdnHist.push_front(pdnIn);
    mLrckPrev = lrckIn;
  endtask

  task automatic compareAll();
    logic [SW-1:0] expL, expR;
    expL = (mState == 3) ? sampleLeftIn : '0;
    expR = (mState == 3) ? sampleRightIn : '0;
    check(seqState == 2'(mState), "R3 R4 R5 R8 state", seqState, mState);
    check(dataValid == (mState == 3), "R7 valid", dataValid, mState == 3);
    check(filterRstN == (mState != 0), "R9 filterRstN", filterRstN, mState != 0);
    check(sampleLeftOut == expL && sampleRightOut == expR, "R6 R7 samples",
          {sampleLeftOut, sampleRightOut}, {expL, expR});
  endtask

  task automatic cycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compareAll();
    if (lrckRun) begin
      lrckDiv++;
      if (lrckDiv == 3) begin lrckIn = ~lrckIn; lrckDiv = 0; end
    end
    sampleLeftIn  = SW'(cyc * 40503 + 17);
    sampleRightIn = ~SW'(cyc * 911);
  endtask

  task automatic runTo(input int st, input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      if (int'(seqState) == st) break;
      cycle();
    end
  endtask

  task automatic mainFlow();
    int lat;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(seqState == 2'd0, "R1 state", seqState, 0);
    check(dataValid == 1'b0 && filterRstN == 1'b0, "R1 flags", {dataValid, filterRstN}, 0);
    check(sampleLeftOut == '0 && sampleRightOut == '0, "R1 samples", sampleLeftOut, 0);

    // master, left-justified: latency of the synchronizer
    masterMode = 1; i2sMode = 0; lrckRun = 1;
    repeat (4) cycle();
    pdnIn = 1'b1;
    lat = 0;
    for (int i = 0; i < 10; i++) begin
      cycle(); lat++;
      if (seqState != 2'd0) break;
    end
    check(lat == 3, "R2 release latency", lat, 3);
    check(seqState == 2'd2, "R3 master skips wait", seqState, 2);
    runTo(3, 200);
    check(dataValid == 1'b1, "R5 master reaches run", dataValid, 1);
    repeat (10) cycle();

    // power down while running
    pdnIn = 1'b0;
    repeat (3) cycle();
    check(seqState == 2'd0 && !dataValid, "R8 drop from run", seqState, 0);

    // slave, left-justified, frame clock held: must wait
    masterMode = 0; i2sMode = 0; lrckRun = 0; lrckIn = 0;
    repeat (3) cycle();
    pdnIn = 1'b1;
    repeat (20) cycle();
    check(seqState == 2'd1, "R4 waits without start edge", seqState, 1);
    lrckRun = 1;
    runTo(2, 50);
    check(lrckIn == 1'b1, "R4 rising start edge", lrckIn, 1);
    runTo(3, 300);
    check(dataValid == 1'b1, "R5 slave reaches run", dataValid, 1);
    repeat (8) cycle();

    // drop during wait
    pdnIn = 1'b0;
    repeat (4) cycle();
    i2sMode = 1; lrckRun = 0;
    pdnIn = 1'b1;
    repeat (6) cycle();
    check(seqState == 2'd1, "R4 i2s waiting", seqState, 1);
    pdnIn = 1'b0;
    repeat (3) cycle();
    check(seqState == 2'd0, "R8 drop from wait", seqState, 0);

    // slave, I2S: drop in the middle of init, then a full recount
    pdnIn = 1'b1; lrckRun = 1;
    runTo(2, 60);
    check(lrckIn == 1'b0, "R4 falling start edge", lrckIn, 0);
    repeat (20) cycle();
    check(seqState == 2'd2, "R5 still initializing", seqState, 2);
    pdnIn = 1'b0;
    repeat (3) cycle();
    check(seqState == 2'd0 && filterRstN == 1'b0, "R8 R9 drop from init", seqState, 0);
    pdnIn = 1'b1;
    runTo(3, 400);
    check(dataValid == 1'b1, "R5 recount completes", dataValid, 1);
    repeat (10) cycle();

    // one-cycle power-down pulse while running still passes the synchronizer
    pdnIn = 1'b0;
    cycle();
    pdnIn = 1'b1;
    repeat (3) cycle();
    check(seqState == 2'd0 || seqState == 2'd1, "R8 short pulse restart", seqState, 1);
    repeat (20) cycle();
  endtask

  initial begin
    bit timedOut;
    timedOut = 0;
    fork
      begin : main_thread
        mainFlow();
      end
      begin : dog_thread
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule